// File: doc/BRIEF.md
# Power-of-Two Ceiling Unit

This block takes an unsigned value of parameterised width and returns the smallest power of two that is not below it. A zero input yields zero. The result is one bit wider than the operand, so an operand above the top half of its range still has a representable answer. Typical uses are sizing buffers and normalising allocation requests.

The unit is purely combinational. It is built as a row of identical one-bit cells, one per operand bit, placed by a generate loop. Status flags travel through the row in both directions. A "nothing set above" flag travels from the most significant cell toward the least significant one. A "something set below" flag travels the other way. A third flag runs upward and lets a cell ask its upper neighbour to raise that neighbour's result bit. Each cell decides its own result bit from these local flags. The request that leaves the top cell becomes the extra result bit.

Top module: `pow2_roundup`

## Requirements
- R1: The result has WIDTH+1 bits. Result bit WIDTH is the only path to 2^WIDTH, for example 255 gives 256 when WIDTH is 8.
- R2: An operand of zero gives a result of zero.
- R3: An operand that is already a power of two is returned unchanged, for example 2 gives 2 and 128 gives 128.
- R4: Any other operand gives the next power of two above it, for example 5 gives 8 and 12 gives 16.
- R5: The result is either zero or has exactly one bit set.
- R6: The result follows the operand with no clock and no storage, and is settled within the same cycle in which the operand changes.
- R7: Result bit WIDTH is 1 exactly when operand bit WIDTH-1 is 1 and at least one lower operand bit is also 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| value_i | input | WIDTH | Unsigned operand |
| ceil_o | output | WIDTH+1 | Smallest power of two not below the operand, or zero |

## Verification
Each result is due zero cycles after its stimulus, because the path from operand to result holds no register. The bench changes the operand on a falling clock edge and samples the result one nanosecond later, well before the next edge. This keeps every check inside the cycle that applied the stimulus. It applies all 256 operands at the default width, then a seeded random sequence and directed boundary values, and compares each result against a reference computed by a bench function.

// File: rtl/pow2_pkg.sv
package pow2_pkg;
  // True when exactly one bit of a zero-extended value is set.
  function automatic logic one_hot(input logic [63:0] v);
    logic [63:0] m;
    m = v & (v - 64'd1);
    return (v != 64'd0) && (m == 64'd0);
  endfunction
endpackage

// File: rtl/rup_cell.sv
module rup_cell (
  input  logic bit_i,       // operand bit of this slice
  input  logic clear_hi_i,  // all higher operand bits are 0
  input  logic seen_lo_i,   // some lower operand bit is 1
  input  logic raise_i,     // lower slice asks this slice to output 1
  output logic clear_hi_o,  // toward lower slice
  output logic seen_lo_o,   // toward higher slice
  output logic raise_o,     // toward higher slice
  output logic bit_o        // result bit of this slice
);
  logic leader;

  always_comb begin
    leader     = bit_i & clear_hi_i;
    clear_hi_o = clear_hi_i & ~bit_i;
    seen_lo_o  = seen_lo_i | bit_i;
    raise_o    = leader & seen_lo_i;
    bit_o      = raise_i | (leader & ~seen_lo_i);
  end

  // R5: a slice raised from below is never itself the leading one
  always_comb begin
    p_raise_exclusive_r5: assert (!(raise_i && raise_o))
      else $error("slice raised and raising at once");
  end
endmodule

// File: rtl/rup_chain.sv
module rup_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] value_i,
  output logic [WIDTH:0]   ceil_o
);
  localparam int NFLAG = WIDTH + 1;

  logic [NFLAG-1:0] clear_hi;  // clear_hi[i+1] feeds slice i
  logic [NFLAG-1:0] seen_lo;   // seen_lo[i] feeds slice i
  logic [NFLAG-1:0] raise;     // raise[i] feeds slice i

  assign clear_hi[WIDTH] = 1'b1;
  assign seen_lo[0]      = 1'b0;
  assign raise[0]        = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    rup_cell u_cell (
      .bit_i      (value_i[i]),
      .clear_hi_i (clear_hi[i+1]),
      .seen_lo_i  (seen_lo[i]),
      .raise_i    (raise[i]),
      .clear_hi_o (clear_hi[i]),
      .seen_lo_o  (seen_lo[i+1]),
      .raise_o    (raise[i+1]),
      .bit_o      (ceil_o[i])
    );
  end

  assign ceil_o[WIDTH] = raise[WIDTH];

  // R2: downward flag reaching the bottom means an all-zero operand
  always_comb begin
    p_zero_gives_zero_r2: assert (!clear_hi[0] || ceil_o == '0)
      else $error("nonzero result for zero operand");
    // R5: upward flag leaving the top means a nonzero operand
    p_single_bit_r5: assert (!seen_lo[WIDTH] || $onehot(ceil_o))
      else $error("result not a single set bit");
  end
endmodule

// File: rtl/pow2_roundup.sv
module pow2_roundup #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] value_i,
  output logic [WIDTH:0]   ceil_o
);
  import pow2_pkg::*;

  localparam int OW = WIDTH + 1;

  logic [OW-1:0] value_ext;

  assign value_ext = {1'b0, value_i};

  rup_chain #(.WIDTH(WIDTH)) u_chain (
    .value_i (value_i),
    .ceil_o  (ceil_o)
  );

  always_comb begin
    // R3: powers of two pass through
    p_pass_pow2_r3: assert (!one_hot(64'(value_ext)) || ceil_o == value_ext)
      else $error("power of two altered");
    // R4: result never below the operand
    p_not_below_r4: assert (value_i == '0 || ceil_o >= value_ext)
      else $error("result below operand");
    // R7: top result bit only when operand MSB is set
    p_top_bit_r7: assert (!ceil_o[WIDTH] || value_i[WIDTH-1])
      else $error("top bit without operand MSB");
  end
endmodule

// File: tb/test_pow2_roundup.sv
module test_pow2_roundup;
  localparam int W = 8;

  logic         clk;
  logic [W-1:0] value;
  logic [W:0]   ceil_r;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  pow2_roundup #(.WIDTH(W)) i_pow2_roundup (
    .value_i (value),
    .ceil_o  (ceil_r)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [W:0] ref_ceil(input logic [W-1:0] v);
    logic [W:0] p;
    if (v == '0) return '0;
    p = 1;
    while (p < {1'b0, v}) p = p << 1;
    return p;
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s value=%0d actual=%0d expected=%0d", req, value, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] v, input string req);
    @(negedge clk);
    value = v;
    #1;
    check(req, ceil_r, ref_ceil(v));
  endtask

  initial begin
    value = '0;
    void'($urandom(32'd4711));
    #1;
    check("R2", ceil_r, '0);                 // start state: zero in, zero out
    apply(8'd0,   "R2");
    apply(8'd2,   "R3");
    apply(8'd1,   "R3");
    apply(8'd128, "R3");
    apply(8'd5,   "R4");
    apply(8'd12,  "R4");
    apply(8'd3,   "R4");
    apply(8'd129, "R1");                      // 129 -> 256
    apply(8'd255, "R1");                      // 255 -> 256
    // R6: result settles in the same cycle the operand changes
    @(negedge clk); value = 8'd100; #1;
    check("R6", ceil_r, 9'd128);
    value = 8'd7; #1;
    check("R6", ceil_r, 9'd8);
    // R7: top bit set iff operand MSB and some lower bit
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); value = 8'(v); #1;
      check("R7", {8'd0, ceil_r[W]}, {8'd0, (value[W-1] & (value[W-2:0] != '0))});
      check("R4", ceil_r, ref_ceil(value));
      check("R5", {8'd0, ($countones(ceil_r) <= 1)}, 9'd1);
    end
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] r;
      r = 8'($urandom);
      if (k % 5 == 0) r = 8'(1 << (k % W));   // mix in powers of two
      apply(r, "R4");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule